// File: doc/BRIEF.md
# Half-Flash Converter Bus Controller

This block holds the digital sequencing and processor-bus logic of an eight-bit, multi-channel half-flash converter. The analog side is reduced to two comparator banks. Each bank delivers a 15-segment thermometer word: a coarse bank for the upper nibble and a fine bank for the lower nibble. The controller starts a conversion when both the chip-select and read strobes are low. At that moment it captures the channel address. It then waits out a tracking interval of TRACK_CYC clocks and stores the coarse nibble. After a further FINE_CYC clocks it stores the fine nibble and signals end of conversion.

A processor uses the block in one of two ways, and no register selects between them. In the wait-state style, the processor keeps read low for the whole conversion. The ready line holds it off until the new result is on the bus. In the non-wait style, a short read returns the result of the previous conversion and starts the next one. A later read collects that next result. The three-state data bus is modelled as a data word plus an output enable. The open-drain ready line is modelled as a pull-low enable.

All inputs are taken as synchronous to `clk`. The active-low reset is asynchronous and must be released synchronously to `clk`.

Top module: `hfadc_bus_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `int_n` is 1, `rdy_pull_lo` is 0, `data_oe` is 0 with both strobes high, and the held result is 0x00.
- R2: A conversion starts at the first clock edge that samples both `cs_n` and `rd_n` low after an edge where at least one was high, provided no conversion is running. `chan_addr` is captured at that edge and shown on `chan_sel` from then on (address value k selects channel k+1).
- R3: The coarse nibble is stored at the edge TRACK_CYC clocks after the start edge, and end of conversion comes FINE_CYC clocks after that. The result is {coarse count, fine count}, where each count is the number of ones in its 15-bit thermometer word. All-zero words give 0x00 and all-ones words give 0xFF.
- R4: `int_n` goes low at the end-of-conversion edge. It returns high at an edge that samples a rising `cs_n` or a rising `rd_n`. If a rising strobe and end of conversion share an edge, `int_n` goes low.
- R5: `rdy_pull_lo` is set at an edge that samples a falling `cs_n`. It is cleared at an edge that samples a rising `cs_n`, or at end of conversion while both strobes are still low.
- R6: If a read that started a conversion is still low when the coarse nibble is stored, the bus is not driven (`data_oe`=0) until end of conversion. From the end-of-conversion edge on, it drives the new result.
- R7: Up to the coarse-store edge, a read that started a conversion sees the previous result on the bus. Any read that did not start a conversion also sees the previous result.
- R8: A start request made while a conversion runs is ignored: `chan_sel` keeps its value and the end-of-conversion edge stays where it was.
- R9: `data_oe` is 1 only while both `cs_n` and `rd_n` are low. A read strobe with chip select high neither drives the bus nor touches `rdy_pull_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| chan_addr | input | ADDR_W | Channel address, captured at start |
| coarse_therm | input | 15 | Coarse comparator bank, thermometer code |
| fine_therm | input | 15 | Fine comparator bank, thermometer code |
| chan_sel | output | ADDR_W | Latched channel address driving the input multiplexer |
| data_out | output | 8 | Held conversion result |
| data_oe | output | 1 | Data bus output enable |
| int_n | output | 1 | Active-low conversion-complete flag |
| rdy_pull_lo | output | 1 | Pull-low enable of the open-drain ready line |

## Verification
End of conversion can land on the same edge as a rising read or chip-select strobe. In that case the end-of-conversion event, which drives `int_n` low, meets a strobe release, which drives it high, and the ready line sees a chip-select rise together with a completion. The bench provokes this by releasing both strobes in the cycle just before the computed end-of-conversion edge. It then requires `int_n` low, ready released and the bus idle. A read-only pulse afterwards must bring `int_n` back high. The bench also fires a second read in the middle of a non-wait conversion and requires the channel and the completion time to stay unchanged.

// File: rtl/hfadc_pkg.sv
package hfadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRACK = 2'd1,
    PH_FINE  = 2'd2
  } phase_t;
endpackage

// File: rtl/hfadc_therm_enc.sv
module hfadc_therm_enc #(
  parameter int SEGS  = 15,
  parameter int OUT_W = 4
) (
  input  logic [SEGS-1:0]  therm,
  output logic [OUT_W-1:0] code
);
  // Count of set segments; a valid thermometer word gives its level directly.
  always_comb begin
    code = '0;
    for (int i = 0; i < SEGS; i++) begin
      code = code + OUT_W'(therm[i]);
    end
  end
endmodule

// File: rtl/hfadc_seq.sv
module hfadc_seq
  import hfadc_pkg::*;
#(
  parameter int TRACK_CYC = 200,
  parameter int FINE_CYC  = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic coarse_stb,
  output logic eoc
);
  localparam int LONGEST = (TRACK_CYC > FINE_CYC) ? TRACK_CYC : FINE_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  phase_t           phase_q, phase_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    phase_nx   = phase_q;
    cnt_nx     = cnt_q;
    coarse_stb = 1'b0;
    eoc        = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_nx = PH_TRACK;
          cnt_nx   = CNT_W'(TRACK_CYC - 1);
        end
      end
      PH_TRACK: begin
        if (cnt_q == '0) begin
          coarse_stb = 1'b1;
          phase_nx   = PH_FINE;
          cnt_nx     = CNT_W'(FINE_CYC - 1);
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
      PH_FINE: begin
        if (cnt_q == '0) begin
          eoc      = 1'b1;
          phase_nx = PH_IDLE;
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_nx;
      cnt_q   <= cnt_nx;
    end
  end

  assign busy = (phase_q != PH_IDLE);
endmodule

// File: rtl/hfadc_bus_ctrl.sv
module hfadc_bus_ctrl #(
  parameter int ADDR_W    = 3,
  parameter int RES_W     = 8,
  parameter int TRACK_CYC = 200,
  parameter int FINE_CYC  = 120
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       rd_n,
  input  logic [ADDR_W-1:0]          chan_addr,
  input  logic [(1<<(RES_W/2))-2:0]  coarse_therm,
  input  logic [(1<<(RES_W/2))-2:0]  fine_therm,
  output logic [ADDR_W-1:0]          chan_sel,
  output logic [RES_W-1:0]           data_out,
  output logic                       data_oe,
  output logic                       int_n,
  output logic                       rdy_pull_lo
);
  localparam int HALF_W = RES_W / 2;
  localparam int SEGS   = (1 << HALF_W) - 1;

  // Strobe history
  logic cs_q, rd_q;
  logic sel, sel_q, cs_fall, cs_rise, rd_rise, start;

  assign sel     = !cs_n && !rd_n;
  assign sel_q   = !cs_q && !rd_q;
  assign cs_fall = !cs_n && cs_q;
  assign cs_rise = cs_n && !cs_q;
  assign rd_rise = rd_n && !rd_q;

  // Sequencer
  logic busy, coarse_stb, eoc;
  assign start = sel && !sel_q && !busy;

  hfadc_seq #(
    .TRACK_CYC (TRACK_CYC),
    .FINE_CYC  (FINE_CYC)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .coarse_stb (coarse_stb),
    .eoc        (eoc)
  );

  // Comparator bank encoders: index 0 coarse, index 1 fine
  logic [HALF_W-1:0] bank_code [2];
  for (genvar g = 0; g < 2; g++) begin : g_enc
    hfadc_therm_enc #(
      .SEGS  (SEGS),
      .OUT_W (HALF_W)
    ) enc_i (
      .therm ((g == 0) ? coarse_therm : fine_therm),
      .code  (bank_code[g])
    );
  end

  // Held state
  logic [ADDR_W-1:0] chan_q;
  logic [HALF_W-1:0] coarse_q;
  logic [RES_W-1:0]  result_q;
  logic              int_q, int_nx;
  logic              rdy_q, rdy_nx;
  logic              wait_q, wait_nx;

  always_comb begin
    int_nx = int_q;
    if (eoc)                   int_nx = 1'b0;
    else if (cs_rise || rd_rise) int_nx = 1'b1;

    rdy_nx = rdy_q;
    if (cs_fall)               rdy_nx = 1'b1;
    else if (cs_rise)          rdy_nx = 1'b0;
    else if (eoc && sel)       rdy_nx = 1'b0;

    wait_nx = wait_q;
    if (coarse_stb && sel)     wait_nx = 1'b1;
    else if (eoc || !sel)      wait_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      rd_q     <= 1'b1;
      chan_q   <= '0;
      coarse_q <= '0;
      result_q <= '0;
      int_q    <= 1'b1;
      rdy_q    <= 1'b0;
      wait_q   <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      rd_q   <= rd_n;
      int_q  <= int_nx;
      rdy_q  <= rdy_nx;
      wait_q <= wait_nx;
      if (start)      chan_q   <= chan_addr;
      if (coarse_stb) coarse_q <= bank_code[0];
      if (eoc)        result_q <= {coarse_q, bank_code[1]};
    end
  end

  assign chan_sel    = chan_q;
  assign data_out    = result_q;
  assign data_oe     = sel && !wait_q;
  assign int_n       = int_q;
  assign rdy_pull_lo = rdy_q;
endmodule

// File: rtl/hfadc_bus_ctrl_chk.sv
module hfadc_bus_ctrl_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic [ADDR_W-1:0] chan_sel,
  input logic              data_oe,
  input logic              int_n,
  input logic              rdy_pull_lo,
  input logic              busy,
  input logic              eoc
);
  // R9
  bus_drive_needs_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!cs_n && !rd_n));

  // R6
  bus_quiet_only_converting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && !data_oe) |-> busy);

  // R4
  int_low_after_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !int_n);

  // R4
  int_high_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(cs_n) || $rose(rd_n)) && !eoc) |=> int_n);

  // R5
  rdy_set_on_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> rdy_pull_lo);

  // R5
  rdy_clear_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !rdy_pull_lo);

  // R8
  chan_held_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(chan_sel));
endmodule

bind hfadc_bus_ctrl hfadc_bus_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .rd_n        (rd_n),
  .chan_sel    (chan_sel),
  .data_oe     (data_oe),
  .int_n       (int_n),
  .rdy_pull_lo (rdy_pull_lo),
  .busy        (busy),
  .eoc         (eoc)
);

// File: tb/hfadc_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module hfadc_bus_ctrl_tb_top;
  localparam int T = 20;
  localparam int F = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [2:0]  chan_addr = '0;
  logic [14:0] coarse_therm = '0;
  logic [14:0] fine_therm = '0;
  logic [2:0]  chan_sel;
  logic [7:0]  data_out;
  logic        data_oe, int_n, rdy_pull_lo;

  int   errs = 0;
  int   checks = 0;
  bit   done = 1'b0;
  logic [7:0] prev_res = 8'h00;

  always #2.5 clk = ~clk;

  hfadc_bus_ctrl #(.ADDR_W(3), .RES_W(8), .TRACK_CYC(T), .FINE_CYC(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .chan_addr(chan_addr),
    .coarse_therm(coarse_therm), .fine_therm(fine_therm), .chan_sel(chan_sel),
    .data_out(data_out), .data_oe(data_oe), .int_n(int_n), .rdy_pull_lo(rdy_pull_lo)
  );

  function automatic logic [14:0] therm(input int n);
    return 15'((32'd1 << n) - 1);
  endfunction

  function automatic logic [7:0] exp_code(input int nc, input int nf);
    return {4'(nc), 4'(nf)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nstep(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Read strobe alone: clears int_n, leaves bus and ready untouched (R4, R9)
  task automatic clear_int();
    rd_n = 1'b0;
    nstep(1);
    chk("R9 rd-only no drive", data_oe, 0);
    chk("R9 rd-only no ready", rdy_pull_lo, 0);
    rd_n = 1'b1;
    nstep(1);
    chk("R4 rd rise clears int", int_n, 1);
    nstep(1);
  endtask

  task automatic conv_wait(input logic [2:0] a, input int nc, input int nf, input bit collide);
    logic [7:0] e;
    e = exp_code(nc, nf);
    cs_n = 1'b0; rd_n = 1'b0; chan_addr = a;
    coarse_therm = therm(nc); fine_therm = therm(nf);
    nstep(1);
    chk("R2 channel latched", chan_sel, a);
    chk("R5 ready pulled", rdy_pull_lo, 1);
    chk("R7 oe during track", data_oe, 1);
    chk("R7 previous data", data_out, prev_res);
    nstep(T - 1);
    chk("R6 oe before coarse", data_oe, 1);
    nstep(1);
    chk("R6 bus released after coarse", data_oe, 0);
    chk("R5 ready held", rdy_pull_lo, 1);
    nstep(F - 1);
    chk("R3 no eoc yet", int_n, 1);
    if (collide) begin
      cs_n = 1'b1; rd_n = 1'b1;
      nstep(1);
      chk("R4 eoc wins over strobe rise", int_n, 0);
      chk("R5 ready released by cs rise", rdy_pull_lo, 0);
      chk("R9 no drive after release", data_oe, 0);
      prev_res = e;
      nstep(1);
      clear_int();
    end else begin
      nstep(1);
      chk("R3 eoc int low", int_n, 0);
      chk("R6 bus driven at eoc", data_oe, 1);
      chk("R3 result", data_out, e);
      chk("R5 ready released at eoc", rdy_pull_lo, 0);
      cs_n = 1'b1; rd_n = 1'b1;
      nstep(1);
      chk("R4 release clears int", int_n, 1);
      chk("R9 no drive after release", data_oe, 0);
      prev_res = e;
      nstep(1);
    end
  endtask

  task automatic conv_nowait(input logic [2:0] a, input int nc, input int nf, input bit extra);
    int cur;
    cs_n = 1'b0; rd_n = 1'b0; chan_addr = a;
    coarse_therm = therm(nc); fine_therm = therm(nf);
    nstep(1);
    chk("R2 channel latched", chan_sel, a);
    chk("R7 previous result driven", data_oe, 1);
    chk("R7 previous data", data_out, prev_res);
    chk("R5 ready pulled", rdy_pull_lo, 1);
    cs_n = 1'b1; rd_n = 1'b1;
    nstep(1);
    chk("R5 ready released on cs rise", rdy_pull_lo, 0);
    chk("R4 int high after read", int_n, 1);
    chk("R9 idle bus", data_oe, 0);
    cur = 2;
    if (extra) begin
      nstep(3);
      cs_n = 1'b0; rd_n = 1'b0; chan_addr = ~a;
      nstep(1);
      chk("R8 channel kept", chan_sel, a);
      chk("R7 read during conversion", data_out, prev_res);
      chk("R5 ready on second select", rdy_pull_lo, 1);
      cs_n = 1'b1; rd_n = 1'b1;
      cur = 6;
    end
    nstep(T + F - cur);
    chk("R8 eoc not early", int_n, 1);
    nstep(1);
    chk("R3 eoc int low", int_n, 0);
    chk("R9 no drive while idle", data_oe, 0);
    prev_res = exp_code(nc, nf);
    nstep(1);
    clear_int();
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_1234);
    nstep(3);
    chk("R1 int reset", int_n, 1);
    chk("R1 ready reset", rdy_pull_lo, 0);
    chk("R1 oe reset", data_oe, 0);
    chk("R1 result reset", data_out, 8'h00);
    rst_n = 1'b1;
    nstep(2);
    chk("R1 int after reset", int_n, 1);

    conv_wait(3'd3, 15, 15, 1'b0);
    conv_nowait(3'd5, 0, 0, 1'b0);
    conv_nowait(3'd6, 7, 9, 1'b1);
    conv_wait(3'd0, 2, 13, 1'b1);
    conv_wait(3'd7, 0, 15, 1'b0);

    for (int i = 0; i < 16; i++) begin
      int unsigned m;
      logic [2:0] a;
      int nc, nf;
      m  = $urandom % 4;
      a  = 3'($urandom % 8);
      nc = int'($urandom % 16);
      nf = int'($urandom % 16);
      case (m)
        0: conv_wait(a, nc, nf, 1'b0);
        1: conv_wait(a, nc, nf, 1'b1);
        2: conv_nowait(a, nc, nf, 1'b0);
        default: conv_nowait(a, nc, nf, 1'b1);
      endcase
    end
    conv_nowait(3'd1, 4, 4, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule